// File: doc/BRIEF.md
# Ordered Three-Entry Combination Lock

This block is a clocked state machine that releases a lock only after three dial entries arrive in one fixed order. Each entry is a turn direction (right or left) and a dial position from 0 to 31. An entry is presented as one beat on a valid/ready input stream. The lock records how far it has progressed through the code in a two-bit state register. It drives an `unlocked` flag while it is open. The whole code has to be entered in sequence. The same three entries in any other order do not open the lock.

The code is a parameter. Its default is right-13, then left-22, then right-3. A wrong entry sends the machine back to the start. The one exception is a wrong entry that is itself the first code entry: that entry counts as a fresh start and moves the machine to the first progress state. Once the lock is open, it stays open until the `relock` pin is pulsed or a synchronous reset is applied. Entries that arrive while the lock is open are accepted and discarded.

The entry stream applies no back-pressure. `entry_ready` is high in every cycle, so every beat with `entry_valid` high is consumed in the cycle it is presented. A source may therefore present a new entry on every clock.

Top module: `seq_lock_fsm`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge sets `lock_state` to 2'b00 (idle) and `unlocked` to 0 after that edge.
- R2: In states 00, 01 and 10, a clock edge with `entry_valid` low leaves `lock_state` unchanged, whatever `relock`, `entry_dir` and `entry_num` are.
- R3: An accepted correct entry advances the state by one step. Right-13 (`entry_dir`=1, `entry_num`=13) in 00 gives 01. Left-22 (`entry_dir`=0, `entry_num`=22) in 01 gives 10. Right-3 in 10 gives 11. Each change is visible after the edge that accepts the entry.
- R4: An accepted entry in 00, 01 or 10 that is not the expected one gives 00. The exception is right-13, which gives 01.
- R5: `unlocked` is 1 exactly when `lock_state` is 2'b11.
- R6: In state 11 with `relock` low, the state stays 11 whatever entries arrive.
- R7: In state 11, `relock` high at a clock edge gives 00, even when an entry is presented in the same cycle. In states 00, 01 and 10, `relock` has no effect.
- R8: `entry_ready` is 1 in every cycle after reset, including while the lock is open.
- R9: The direction is part of every code entry. An entry with the correct dial number and the wrong direction counts as a wrong entry under R4. For example, left-13 in 00 stays 00, and right-22 in 01 gives 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| entry_valid | input | 1 | An entry is presented this cycle |
| entry_ready | output | 1 | Entry accepted this cycle (always 1) |
| entry_dir | input | 1 | Turn direction: 1 = right, 0 = left |
| entry_num | input | 5 | Dial position 0..31 |
| relock | input | 1 | Close an open lock |
| unlocked | output | 1 | Lock is open (state 11) |
| lock_state | output | 2 | Progress: 00 idle, 01 first done, 10 second done, 11 open |

## Verification
The assertions check the following rules on every cycle:
- the reset result;
- that the state holds on edges without an entry;
- that the machine never skips a progress step;
- that the open state persists, and that relock exits it;
- that `unlocked` agrees with the state register.

The exact destination of each entry cannot be shown by a per-cycle property. This covers the restart on right-13, the direction sensitivity, and dropping a wrong entry back to idle. Only the bench's sweeps show these. The sweeps cover every start state, every direction, every dial value and both relock levels, and a long mixed stream is compared against an arithmetic model.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  localparam int STATE_W = 2;
  localparam int STEPS   = 3;

  typedef enum logic [STATE_W-1:0] {
    LK_IDLE   = 2'b00,
    LK_FIRST  = 2'b01,
    LK_SECOND = 2'b10,
    LK_OPEN   = 2'b11
  } lock_state_e;

endpackage

// File: rtl/seq_lock_match.sv
module seq_lock_match #(
  parameter int                              DIAL_W   = 5,
  parameter int                              STEPS    = 3,
  parameter logic [STEPS-1:0]                CODE_DIR = 3'b101,
  parameter logic [STEPS-1:0][DIAL_W-1:0]    CODE_NUM = {5'd3, 5'd22, 5'd13}
) (
  input  logic              dir,
  input  logic [DIAL_W-1:0] num,
  output logic [STEPS-1:0]  hit
);

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    assign hit[k] = (dir == CODE_DIR[k]) && (num == CODE_NUM[k]);
  end

endmodule

// File: rtl/seq_lock_next.sv
module seq_lock_next
  import seq_lock_pkg::*;
(
  input  lock_state_e        cur,
  input  logic               take,
  input  logic               relock,
  input  logic [STEPS-1:0]   hit,
  output lock_state_e        nxt
);

  lock_state_e restart;

  // A wrong entry that is itself the first code entry counts as a new start.
  always_comb begin
    restart = hit[0] ? LK_FIRST : LK_IDLE;
  end

  always_comb begin
    nxt = cur;
    unique case (cur)
      LK_IDLE:   if (take) nxt = restart;
      LK_FIRST:  if (take) nxt = hit[1] ? LK_SECOND : restart;
      LK_SECOND: if (take) nxt = hit[2] ? LK_OPEN   : restart;
      LK_OPEN:   if (relock) nxt = LK_IDLE;
      default:   nxt = LK_IDLE;
    endcase
  end

endmodule

// File: rtl/seq_lock_state.sv
module seq_lock_state
  import seq_lock_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic         relock,
  input  lock_state_e  nxt,
  output lock_state_e  cur,
  output logic         open_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= LK_IDLE;
      open_q <= 1'b0;
    end else begin
      cur    <= nxt;
      open_q <= (nxt == LK_OPEN);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (cur == LK_IDLE) && !open_q);

  assert_hold_no_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (!take && cur != LK_OPEN) |=> cur == $past(cur));

  assert_no_skip_from_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (cur == LK_IDLE) |=> (cur == LK_IDLE || cur == LK_FIRST));

  assert_no_skip_from_first_R3: assert property (@(posedge clk) disable iff (rst)
    (cur == LK_FIRST) |=> (cur != LK_OPEN));

  assert_open_flag_R5: assert property (@(posedge clk) disable iff (rst)
    open_q == (cur == LK_OPEN));

  assert_open_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (cur == LK_OPEN && !relock) |=> cur == LK_OPEN);

  assert_relock_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (cur == LK_OPEN && relock) |=> cur == LK_IDLE);

endmodule

// File: rtl/seq_lock_fsm.sv
module seq_lock_fsm
  import seq_lock_pkg::*;
#(
  parameter int                            DIAL_W   = 5,
  parameter logic [STEPS-1:0]              CODE_DIR = 3'b101,
  parameter logic [STEPS-1:0][DIAL_W-1:0]  CODE_NUM = {5'd3, 5'd22, 5'd13}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              entry_valid,
  output logic              entry_ready,
  input  logic              entry_dir,
  input  logic [DIAL_W-1:0] entry_num,
  input  logic              relock,
  output logic              unlocked,
  output logic [STATE_W-1:0] lock_state
);

  logic [STEPS-1:0] hit;
  logic             take;
  lock_state_e      cur;
  lock_state_e      nxt;

  // No back-pressure: every presented entry is consumed in its cycle.
  assign entry_ready = 1'b1;
  assign take        = entry_valid && entry_ready;

  seq_lock_match #(
    .DIAL_W   (DIAL_W),
    .STEPS    (STEPS),
    .CODE_DIR (CODE_DIR),
    .CODE_NUM (CODE_NUM)
  ) u_match (
    .dir (entry_dir),
    .num (entry_num),
    .hit (hit)
  );

  seq_lock_next u_next (
    .cur    (cur),
    .take   (take),
    .relock (relock),
    .hit    (hit),
    .nxt    (nxt)
  );

  seq_lock_state u_state (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .relock (relock),
    .nxt    (nxt),
    .cur    (cur),
    .open_q (unlocked)
  );

  assign lock_state = cur;

  assert_ready_R8: assert property (@(posedge clk) disable iff (rst)
    entry_valid |-> entry_ready);

endmodule

// File: tb/test_seq_lock_fsm.sv
module test_seq_lock_fsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       entry_valid = 1'b0;
  logic       entry_ready;
  logic       entry_dir = 1'b0;
  logic [4:0] entry_num = 5'd0;
  logic       relock = 1'b0;
  logic       unlocked;
  logic [1:0] lock_state;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  seq_lock_fsm i_seq_lock_fsm (
    .clk         (clk),
    .rst         (rst),
    .entry_valid (entry_valid),
    .entry_ready (entry_ready),
    .entry_dir   (entry_dir),
    .entry_num   (entry_num),
    .relock      (relock),
    .unlocked    (unlocked),
    .lock_state  (lock_state)
  );

  // Reference model built from the requirements.
  function automatic logic [1:0] model(input logic [1:0] s, input logic v,
                                       input logic d, input logic [4:0] n,
                                       input logic rl);
    logic first_code;
    first_code = (d == 1'b1) && (n == 5'd13);
    if (s == 2'd3) return rl ? 2'd0 : 2'd3;
    if (!v) return s;
    if (s == 2'd0 && first_code) return 2'd1;
    if (s == 2'd1 && d == 1'b0 && n == 5'd22) return 2'd2;
    if (s == 2'd2 && d == 1'b1 && n == 5'd3) return 2'd3;
    return first_code ? 2'd1 : 2'd0;
  endfunction

  function automatic string tag(input logic [1:0] s, input logic v,
                                input logic d, input logic [4:0] n,
                                input logic rl);
    if (s == 2'd3) return rl ? "R7" : "R6";
    if (!v) return "R2";
    if (model(s, v, d, n, rl) == s + 2'd1) return "R3";
    if ((s == 2'd0 && n == 5'd13) || (s == 2'd1 && n == 5'd22) ||
        (s == 2'd2 && n == 5'd3)) return "R9";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; entry_valid = 1'b0; relock = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic v, input logic d, input logic [4:0] n, input logic rl);
    @(negedge clk);
    entry_valid = v; entry_dir = d; entry_num = n; relock = rl;
    @(posedge clk); #1;
    entry_valid = 1'b0; relock = 1'b0;
  endtask

  task automatic go_to(input logic [1:0] s);
    do_reset();
    if (s >= 2'd1) step(1'b1, 1'b1, 5'd13, 1'b0);
    if (s >= 2'd2) step(1'b1, 1'b0, 5'd22, 1'b0);
    if (s >= 2'd3) step(1'b1, 1'b1, 5'd3,  1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] exp_s;
    logic [1:0] ms;
    logic [15:0] lfsr;

    // R1: reset state
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check(lock_state == 2'd0, "R1 state", lock_state, 0);
    check(unlocked == 1'b0, "R1 unlocked", unlocked, 0);
    @(negedge clk);
    rst = 1'b0;

    // R3: full code in order, each step observed
    step(1'b1, 1'b1, 5'd13, 1'b0);
    check(lock_state == 2'd1, "R3 step1", lock_state, 1);
    step(1'b1, 1'b0, 5'd22, 1'b0);
    check(lock_state == 2'd2, "R3 step2", lock_state, 2);
    step(1'b1, 1'b1, 5'd3, 1'b0);
    check(lock_state == 2'd3, "R3 step3", lock_state, 3);
    check(unlocked == 1'b1, "R5 open", unlocked, 1);

    // R1: reset from open
    do_reset();
    check(lock_state == 2'd0, "R1 from open", lock_state, 0);

    // Exhaustive sweep: start state x relock x valid x dir x num
    for (int s = 0; s < 4; s++) begin
      for (int rl = 0; rl < 2; rl++) begin
        for (int v = 0; v < 2; v++) begin
          for (int d = 0; d < 2; d++) begin
            for (int n = 0; n < 32; n++) begin
              go_to(2'(s));
              exp_s = model(2'(s), 1'(v), 1'(d), 5'(n), 1'(rl));
              @(negedge clk);
              entry_valid = 1'(v); entry_dir = 1'(d); entry_num = 5'(n); relock = 1'(rl);
              #1;
              check(entry_ready == 1'b1, "R8 ready", entry_ready, 1);
              @(posedge clk); #1;
              entry_valid = 1'b0; relock = 1'b0;
              check(lock_state == exp_s,
                    tag(2'(s), 1'(v), 1'(d), 5'(n), 1'(rl)), lock_state, exp_s);
              check(unlocked == (exp_s == 2'd3), "R5 flag", unlocked, exp_s == 2'd3);
            end
          end
        end
      end
    end

    // Long mixed stream against the model
    do_reset();
    ms = 2'd0;
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic v, d, rl;
      logic [4:0] n;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v  = lfsr[0] | lfsr[1];
      rl = (lfsr[4:2] == 3'd0);
      case (lfsr[7:5])
        3'd0, 3'd1: begin d = 1'b1; n = 5'd13; end
        3'd2, 3'd3: begin d = 1'b0; n = 5'd22; end
        3'd4, 3'd5: begin d = 1'b1; n = 5'd3;  end
        default:    begin d = lfsr[8]; n = lfsr[13:9]; end
      endcase
      exp_s = model(ms, v, d, n, rl);
      step(v, d, n, rl);
      check(lock_state == exp_s, tag(ms, v, d, n, rl), lock_state, exp_s);
      check(unlocked == (exp_s == 2'd3), "R5 stream", unlocked, exp_s == 2'd3);
      ms = exp_s;
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule